// File: doc/BRIEF.md
# Frame-Synchronous Control Register Bank for a Picture-in-Picture Engine

This block keeps the control settings of a picture-in-picture engine in two layers. A register write port (address, data, strobe) fills a front layer; a working layer feeds the video datapath. Registers that shape the inset picture (enables, window placement and size, border geometry and style, replay selection) are staged: a new value only reaches the working layer when the main-channel vertical sync rises, so the inset never changes part-way through a field. While the freeze bit is set, vertical syncs are ignored for the staged set; once it is cleared, everything written in the meantime moves across together at the next sync.

The freeze bit, the range-limit bit and the acquisition horizontal offset are direct registers: a write reaches the working layer on the next clock, whatever the freeze bit and the sync are doing. The offset output is clamped to a parameterised limit when the range-limit bit is 0.

Top module: `pip_shadow_bank`

## Requirements
- R1: After reset the staged outputs are 0 except horizontal border code 2 (4 pixels) and vertical border code 2 (2 lines); freeze is 0, full-range is 1, offset is 0.
- R2: Address map: 0 = {bit1 sub enable, bit0 main enable}, 1 window x, 2 window y, 3 window width, 4 window height, 5 = {bits 5:3 vertical border, bits 2:0 horizontal border}, 6 border style, 7 replay select (bits 5:0), 8 = {bit1 full-range, bit0 freeze}, 9 acquisition offset. Writes to 0..7 leave the outputs unchanged until a commit; a commit copies all staged values on the second clock edge after the main vsync is first seen high.
- R3: While freeze is 1, a rising vsync changes no staged output.
- R4: Clearing freeze causes no transfer by itself; all values staged meanwhile appear together at the next rising vsync.
- R5: Writes to addresses 8 and 9 appear on the outputs one clock later, regardless of freeze and vsync.
- R6: A staged write made in the cycle of a commit is not part of that commit; it appears at the following rising vsync.
- R7: With full-range 0 the offset output is min(written value, 63); with full-range 1 it equals the written value.
- R8: Writes to addresses 10 to 15 change no output.
- R9: A vsync held high commits once; writes made while it stays high wait for the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Write data |
| vsync_main | input | 1 | Main-channel vertical sync, active high |
| main_en | output | 1 | Main inset enable |
| sub_en | output | 1 | Sub inset enable |
| win_x | output | 8 | Window horizontal position |
| win_y | output | 8 | Window vertical position |
| win_w | output | 8 | Window width |
| win_h | output | 8 | Window height |
| bord_hcode | output | 3 | Horizontal border width, 2-pixel steps |
| bord_vcode | output | 3 | Vertical border width, 1-line steps |
| bord_style | output | 8 | Border colour and brightness |
| replay_sel | output | 6 | Replay picture select |
| freeze_on | output | 1 | Freeze bit |
| full_range | output | 1 | Range-limit bit |
| acq_hoff | output | 8 | Acquisition horizontal offset after clamp |

## Verification
The properties assume the sync is a level signal that stays high for at least one clock, and that reset is held long enough to flush the edge detector; they also assume the write strobe is low during reset. The stimulus raises vsync for three clocks and then lowers it, holds it high across writes only in a directed case, and drives writes and sync changes at the falling clock edge so every property sees clean sampled values.

// File: rtl/pip_shadow_pkg.sv
package pip_shadow_pkg;
    localparam int DW       = 8;
    localparam int AW       = 4;
    localparam int NHELD    = 8;
    localparam int A_MODE   = 8;
    localparam int A_HOFF   = 9;
    localparam int EN_W     = 2;
    localparam int BORD_W   = 3;
    localparam int SEL_W    = 6;
    localparam int MODE_W   = 2;

    function automatic logic [DW-1:0] held_reset(input int idx);
        logic [DW-1:0] v;
        v = '0;
        if (idx == 5) begin
            v[BORD_W-1:0]        = BORD_W'(2);
            v[2*BORD_W-1:BORD_W] = BORD_W'(2);
        end
        return v;
    endfunction

    typedef struct packed {
        logic vs;
        logic commit;
    } edge_st_t;
endpackage

// File: rtl/pip_vs_edge.sv
module pip_vs_edge
    import pip_shadow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vsync,
    input  logic freeze,
    output logic commit
);
    edge_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.vs     = vsync;
        st_d.commit = vsync & ~st_q.vs & ~freeze;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{vs: 1'b1, commit: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign commit = st_q.commit;
endmodule

// File: rtl/pip_shadow_cell.sv
module pip_shadow_cell #(
    parameter int           W    = 8,
    parameter bit           HELD = 1'b1,
    parameter logic [W-1:0] RST  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  logic [W-1:0] wr_data,
    input  logic         commit,
    output logic [W-1:0] value
);
    generate
        if (HELD) begin : g_staged
            typedef struct packed {
                logic [W-1:0] front;
                logic [W-1:0] work;
            } cell_st_t;
            cell_st_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (commit) st_d.work  = st_q.front;
                if (wr_hit) st_d.front = wr_data;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_q <= '{front: RST, work: RST};
                end else begin
                    st_q <= st_d;
                end
            end

            assign value = st_q.work;
        end else begin : g_direct
            logic [W-1:0] val_d, val_q;
            logic         unused_commit;

            assign unused_commit = commit;

            always_comb begin
                val_d = val_q;
                if (wr_hit) val_d = wr_data;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    val_q <= RST;
                end else begin
                    val_q <= val_d;
                end
            end

            assign value = val_q;
        end
    endgenerate
endmodule

// File: rtl/pip_range_clamp.sv
module pip_range_clamp #(
    parameter int          W     = 8,
    parameter int unsigned LIMIT = 63
) (
    input  logic [W-1:0] raw,
    input  logic         full,
    output logic [W-1:0] eff
);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    always_comb begin
        eff = raw;
        if (!full && (raw > LIM)) eff = LIM;
    end
endmodule

// File: rtl/pip_shadow_bank.sv
module pip_shadow_bank
    import pip_shadow_pkg::*;
#(
    parameter int unsigned HOFF_LIMIT = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              vsync_main,
    output logic              main_en,
    output logic              sub_en,
    output logic [DW-1:0]     win_x,
    output logic [DW-1:0]     win_y,
    output logic [DW-1:0]     win_w,
    output logic [DW-1:0]     win_h,
    output logic [BORD_W-1:0] bord_hcode,
    output logic [BORD_W-1:0] bord_vcode,
    output logic [DW-1:0]     bord_style,
    output logic [SEL_W-1:0]  replay_sel,
    output logic              freeze_on,
    output logic              full_range,
    output logic [DW-1:0]     acq_hoff
);
    localparam logic [MODE_W-1:0] MODE_RST = MODE_W'(2);

    logic [DW-1:0]       held_w [NHELD];
    logic [NHELD*DW-1:0] held_bus_w;
    logic [MODE_W-1:0]   mode_w;
    logic [DW-1:0]       hoff_raw_w;
    logic                commit_w;

    pip_vs_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .vsync  (vsync_main),
        .freeze (mode_w[0]),
        .commit (commit_w)
    );

    generate
        for (genvar i = 0; i < NHELD; i++) begin : g_held
            pip_shadow_cell #(
                .W    (DW),
                .HELD (1'b1),
                .RST  (held_reset(i))
            ) u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_hit  (wr_en && (wr_addr == AW'(i))),
                .wr_data (wr_data),
                .commit  (commit_w),
                .value   (held_w[i])
            );
            assign held_bus_w[i*DW +: DW] = held_w[i];
        end
    endgenerate

    pip_shadow_cell #(
        .W    (MODE_W),
        .HELD (1'b0),
        .RST  (MODE_RST)
    ) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_en && (wr_addr == AW'(A_MODE))),
        .wr_data (wr_data[MODE_W-1:0]),
        .commit  (commit_w),
        .value   (mode_w)
    );

    pip_shadow_cell #(
        .W    (DW),
        .HELD (1'b0),
        .RST  ('0)
    ) u_hoff (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_en && (wr_addr == AW'(A_HOFF))),
        .wr_data (wr_data),
        .commit  (commit_w),
        .value   (hoff_raw_w)
    );

    pip_range_clamp #(
        .W     (DW),
        .LIMIT (HOFF_LIMIT)
    ) u_clamp (
        .raw  (hoff_raw_w),
        .full (mode_w[1]),
        .eff  (acq_hoff)
    );

    assign main_en    = held_w[0][0];
    assign sub_en     = held_w[0][1];
    assign win_x      = held_w[1];
    assign win_y      = held_w[2];
    assign win_w      = held_w[3];
    assign win_h      = held_w[4];
    assign bord_hcode = held_w[5][BORD_W-1:0];
    assign bord_vcode = held_w[5][2*BORD_W-1:BORD_W];
    assign bord_style = held_w[6];
    assign replay_sel = held_w[7][SEL_W-1:0];
    assign freeze_on  = mode_w[0];
    assign full_range = mode_w[1];
endmodule

// File: rtl/pip_shadow_chk.sv
module pip_shadow_chk
    import pip_shadow_pkg::*;
#(
    parameter int unsigned LIMIT = 63
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [AW-1:0]       wr_addr,
    input logic [DW-1:0]       wr_data,
    input logic                vsync_main,
    input logic                freeze_on,
    input logic                full_range,
    input logic                commit,
    input logic [NHELD*DW-1:0] held_bus,
    input logic [DW-1:0]       acq_hoff
);
    // R2: staged outputs move only in the cycle after a commit pulse
    a_r2_held_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(held_bus));

    // R3: a commit pulse needs a sampled high vsync with freeze clear
    a_r3_commit_needs_unfrozen_sync: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ($past(vsync_main) && !$past(freeze_on)));

    // R9: a level vsync cannot produce back-to-back commits
    a_r9_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    // R7: limited range keeps the offset at or below the limit
    a_r7_clamp_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !full_range |-> (acq_hoff <= DW'(LIMIT)));

    // R5: an offset write shows one clock later when full range is on
    a_r5_offset_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == AW'(A_HOFF)) && full_range) |=> (acq_hoff == $past(wr_data)));
endmodule

bind pip_shadow_bank pip_shadow_chk #(.LIMIT(HOFF_LIMIT)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .vsync_main (vsync_main),
    .freeze_on  (freeze_on),
    .full_range (full_range),
    .commit     (commit_w),
    .held_bus   (held_bus_w),
    .acq_hoff   (acq_hoff)
);

// File: tb/pip_shadow_bank_tb.sv
module pip_shadow_bank_tb_top;
    localparam int CLK_NS = 20;
    localparam int LIM    = 63;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       vsync_main = 1'b0;
    logic       main_en, sub_en, freeze_on, full_range;
    logic [7:0] win_x, win_y, win_w, win_h, bord_style, acq_hoff;
    logic [2:0] bord_hcode, bord_vcode;
    logic [5:0] replay_sel;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [7:0] m_front [8];
    logic [7:0] m_work  [8];
    logic [1:0] m_mode;
    logic [7:0] m_hoff;

    always #(CLK_NS/2) clk = ~clk;

    pip_shadow_bank dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .vsync_main(vsync_main),
        .main_en(main_en), .sub_en(sub_en), .win_x(win_x), .win_y(win_y),
        .win_w(win_w), .win_h(win_h), .bord_hcode(bord_hcode),
        .bord_vcode(bord_vcode), .bord_style(bord_style),
        .replay_sel(replay_sel), .freeze_on(freeze_on),
        .full_range(full_range), .acq_hoff(acq_hoff)
    );

    function automatic logic [63:0] exp_held();
        return {m_work[7] & 8'h3F, m_work[6], m_work[5] & 8'h3F, m_work[4],
                m_work[3], m_work[2], m_work[1], m_work[0] & 8'h03};
    endfunction

    function automatic logic [7:0] exp_hoff();
        if (!m_mode[1] && m_hoff > 8'(LIM)) return 8'(LIM);
        return m_hoff;
    endfunction

    function automatic logic [63:0] got_held();
        return {2'b0, replay_sel, bord_style, 2'b0, bord_vcode, bord_hcode,
                win_h, win_w, win_y, win_x, 6'b0, sub_en, main_en};
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, got_held(), exp_held());
        chk(req, 64'({full_range, freeze_on}), 64'(m_mode));
        chk(req, 64'(acq_hoff), 64'(exp_hoff()));
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin
            m_front[i] = '0;
            m_work[i]  = '0;
        end
        m_front[5] = 8'h12;
        m_work[5]  = 8'h12;
        m_mode = 2'b10;
        m_hoff = '0;
    endtask

    task automatic model_wr(input logic [3:0] a, input logic [7:0] d);
        if (a < 8) m_front[a] = d;
        else if (a == 8) m_mode = d[1:0];
        else if (a == 9) m_hoff = d;
    endtask

    task automatic model_commit();
        for (int i = 0; i < 8; i++) m_work[i] = m_front[i];
    endtask

    task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_wr(a, d);
    endtask

    task automatic do_vsync(input string req);
        bit frz;
        frz = m_mode[0];
        vsync_main = 1'b1;
        @(negedge clk);
        chk(req, got_held(), exp_held());
        @(negedge clk);
        if (!frz) model_commit();
        @(negedge clk);
        vsync_main = 1'b0;
        @(negedge clk);
        check_all(req);
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog got=hung exp=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        // R2: staged writes wait for vsync
        for (int i = 0; i < 8; i++) do_wr(4'(i), 8'(8'h31 + 8'(i * 17)));
        check_all("R2 before sync");
        do_vsync("R2 commit");

        // R3 and R4: freeze then release
        do_wr(4'd8, 8'h03);
        do_wr(4'd1, 8'hA5);
        do_wr(4'd5, 8'h2B);
        do_wr(4'd7, 8'hFF);
        do_vsync("R3 frozen");
        do_wr(4'd8, 8'h02);
        check_all("R4 release alone");
        do_vsync("R4 release commit");

        // R5 and R7: direct registers
        do_wr(4'd8, 8'h03);
        do_wr(4'd9, 8'd200);
        check_all("R5 offset direct");
        do_wr(4'd8, 8'h01);
        check_all("R7 clamp low range");
        do_wr(4'd9, 8'd10);
        check_all("R7 below limit");
        do_wr(4'd9, 8'd63);
        check_all("R7 at limit");
        do_wr(4'd8, 8'h02);
        check_all("R5 mode direct");

        // R6: write in commit cycle
        do_wr(4'd2, 8'h11);
        vsync_main = 1'b1;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd2; wr_data = 8'h77;
        @(negedge clk);
        wr_en = 1'b0;
        model_commit();
        model_wr(4'd2, 8'h77);
        vsync_main = 1'b0;
        @(negedge clk);
        check_all("R6 collision excluded");
        do_vsync("R6 next sync");

        // R8: unmapped addresses
        for (int a = 10; a < 16; a++) do_wr(4'(a), 8'hEE);
        check_all("R8 unmapped direct");
        do_vsync("R8 unmapped staged");

        // R9: vsync held high
        vsync_main = 1'b1;
        repeat (3) @(negedge clk);
        model_commit();
        do_wr(4'd3, 8'h5C);
        repeat (3) @(negedge clk);
        check_all("R9 level high");
        vsync_main = 1'b0;
        @(negedge clk);
        check_all("R9 after fall");
        do_vsync("R9 next rise");

        // random mix
        for (int k = 0; k < 400; k++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 6) begin
                do_wr(4'($urandom_range(0, 15)), 8'($urandom));
                check_all("R2 R5 R8 random write");
            end else if (op < 7) begin
                do_wr(4'd8, 8'($urandom_range(0, 3)));
                check_all("R5 random mode");
            end else begin
                do_vsync("R3 R4 random sync");
            end
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule